// File: doc/BRIEF.md
# Configurable Byte/Word Programmable Read-Only Memory Emulator

This block models a one-time-programmable memory whose array is logically 16 bits wide, in synthesizable form. A host reads it either as 16-bit words or as 8-bit bytes. In byte organisation, the top data pin turns into an extra low-order address input that selects one half of the addressed word.

The block decodes the following from two active-low enables, an organisation select and two high-voltage flags:

- normal reads
- output disable
- standby
- an identification code readout
- programming
- program verify
- program inhibit

Programming can only clear bits. An erase input stands in for ultraviolet exposure and restores every word to all ones.

All data and output-enable results are registered, so they appear one clock after the inputs are applied. Tristating is modelled by a three-bit output-enable vector, with one bit per pin group. An integrating design combines `dq_out` and `dq_oe` into real pad drivers.

Top module: `eprom_emu`

## Requirements
- R1: After reset `dq_oe` is 3'b000, `dq_out` is zero, and every word reads 16'hFFFF.
- R2: With `ce_n`=0, `oe_n`=0, `word_sel`=1, `vpp_hi`=0 and `a9_hi`=0, one clock later `dq_out` holds the addressed word and `dq_oe`=3'b111. In `dq_oe`, bit 0 is pins 7..0, bit 1 is pins 14..8 and bit 2 is pin 15.
- R3: In the same read with `word_sel`=0, `dq_in[15]` acts as the half select. Value 0 returns bits 7..0 of the word on `dq_out[7:0]` and value 1 returns bits 15..8. In both cases `dq_out[15:8]`=0 and `dq_oe`=3'b001.
- R4: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0, outputs are off one clock later: `dq_oe`=0 and `dq_out`=0.
- R5: With `ce_n`=1, outputs are off one clock later whatever `oe_n` is.
- R6: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `a9_hi`=1, the low byte is 8'h20 when `addr[0]`=0 and 8'hB8 when `addr[0]`=1. The upper byte is zero. `dq_oe` is 3'b111 in word organisation and 3'b001 in byte organisation.
- R7: A program cycle has two steps. First `vpp_hi`=1, `oe_n`=1 and `ce_n`=0 are sampled on one edge. Then `ce_n`=1 with `vpp_hi`=1 is sampled on a later edge. On that later edge the word at `addr` becomes the old word AND `dq_in`, so a bit at 0 never returns to 1.
- R8: With `vpp_hi`=1, `ce_n`=0 and `oe_n`=0, the stored word drives all 16 outputs with `dq_oe`=3'b111, even in byte organisation.
- R9: With `vpp_hi`=1 and `ce_n`=1 and no prior program setup, outputs are off and the array is unchanged.
- R10: `erase`=1 on one edge sets every word to 16'hFFFF. This takes priority over a program commit on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the array resets to all ones |
| erase | input | 1 | Erase request; sets all words to ones |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_sel | input | 1 | 1 = word organisation, 0 = byte organisation |
| vpp_hi | input | 1 | Program supply at high voltage |
| a9_hi | input | 1 | Identification pin at high voltage |
| addr | input | AW | Word address |
| dq_in | input | 16 | Data pins as driven by the host; bit 15 is the half select in byte organisation |
| dq_out | output | 16 | Registered output data |
| dq_oe | output | 3 | Registered output enables per pin group |

## Verification
A table of vectors covers three kinds of read over programmed and erased words:

- Word reads and both byte halves of the same word. These separate a swapped or missing half select from correct lane steering.
- Identification reads in both organisations and at both values of the low address bit. These catch code swaps and wrong enable width.
- Disable, standby, verify and inhibit vectors. These check that only the decoded mode, and not a lower-priority one, decides the enables.

Directed sequences then reprogram a word with a pattern that tries to set cleared bits, which exposes any overwrite in place of an AND. They also hold the supply flag with no enable pulse, which must leave the array intact. Finally they raise erase on the same edge as a commit, which shows the priority.

// File: rtl/eprom_emu_pkg.sv
package eprom_emu_pkg;
    localparam int DW  = 16;
    localparam int BW  = 8;
    localparam int OEW = 3;

    localparam logic [BW-1:0] MFR_CODE = 8'h20;
    localparam logic [BW-1:0] DEV_CODE = 8'hB8;

    localparam logic [OEW-1:0] OE_NONE = 3'b000;
    localparam logic [OEW-1:0] OE_LOW  = 3'b001;
    localparam logic [OEW-1:0] OE_ALL  = 3'b111;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_INHIBIT,
        M_DISABLE,
        M_PROGRAM,
        M_VERIFY,
        M_SIGNATURE,
        M_READ_WORD,
        M_READ_BYTE
    } mode_e;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_emu_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  word_sel,
    input  logic  vpp_hi,
    input  logic  a9_hi,
    output mode_e mode
);
    always_comb begin
        if (ce_n) begin
            mode = vpp_hi ? M_INHIBIT : M_STANDBY;
        end else if (oe_n) begin
            mode = vpp_hi ? M_PROGRAM : M_DISABLE;
        end else if (vpp_hi) begin
            mode = M_VERIFY;
        end else if (a9_hi) begin
            mode = M_SIGNATURE;
        end else if (word_sel) begin
            mode = M_READ_WORD;
        end else begin
            mode = M_READ_BYTE;
        end
    end
endmodule

// File: rtl/eprom_array.sv
module eprom_array
    import eprom_emu_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase,
    input  mode_e         mode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_word,
    output logic [DW-1:0] rd_word
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic                     armed;
    } arr_t;

    arr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.armed = (mode == M_PROGRAM);
        if (erase) begin
            s_d.mem   = '1;
            s_d.armed = 1'b0;
        end else if (s_q.armed && (mode == M_INHIBIT)) begin
            s_d.mem[addr] = s_q.mem[addr] & wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mem   <= '1;
            s_q.armed <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_word = s_q.mem[addr];
endmodule

// File: rtl/eprom_out_stage.sv
module eprom_out_stage
    import eprom_emu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  mode_e          mode,
    input  logic           word_sel,
    input  logic           a0,
    input  logic           half_sel,
    input  logic [DW-1:0]  rd_word,
    output logic [DW-1:0]  dq_out,
    output logic [OEW-1:0] dq_oe
);
    typedef struct packed {
        logic [DW-1:0]  dq;
        logic [OEW-1:0] oe;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = '0;
        unique case (mode)
            M_READ_WORD, M_VERIFY: begin
                o_d.dq = rd_word;
                o_d.oe = OE_ALL;
            end
            M_READ_BYTE: begin
                o_d.dq = {{BW{1'b0}}, half_sel ? rd_word[DW-1:BW] : rd_word[BW-1:0]};
                o_d.oe = OE_LOW;
            end
            M_SIGNATURE: begin
                o_d.dq = {{BW{1'b0}}, a0 ? DEV_CODE : MFR_CODE};
                o_d.oe = word_sel ? OE_ALL : OE_LOW;
            end
            default: o_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign dq_out = o_q.dq;
    assign dq_oe  = o_q.oe;
endmodule

// File: rtl/eprom_emu.sv
module eprom_emu
    import eprom_emu_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           erase,
    input  logic           ce_n,
    input  logic           oe_n,
    input  logic           word_sel,
    input  logic           vpp_hi,
    input  logic           a9_hi,
    input  logic [AW-1:0]  addr,
    input  logic [15:0]    dq_in,
    output logic [15:0]    dq_out,
    output logic [2:0]     dq_oe
);
    mode_e         mode;
    logic [DW-1:0] rd_word;

    eprom_mode_dec u_dec (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .word_sel (word_sel),
        .vpp_hi   (vpp_hi),
        .a9_hi    (a9_hi),
        .mode     (mode)
    );

    eprom_array #(.DEPTH(DEPTH)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .mode    (mode),
        .addr    (addr),
        .wr_word (dq_in),
        .rd_word (rd_word)
    );

    eprom_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .word_sel (word_sel),
        .a0       (addr[0]),
        .half_sel (dq_in[DW-1]),
        .rd_word  (rd_word),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );
endmodule

// File: rtl/eprom_emu_chk.sv
module eprom_emu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        oe_n,
    input logic        word_sel,
    input logic        vpp_hi,
    input logic        a9_hi,
    input logic [15:0] dq_out,
    input logic [2:0]  dq_oe
);
    assert_standby_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ce_n)) |-> (dq_oe == 3'b000));

    assert_disable_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ce_n && oe_n && !vpp_hi)) |-> (dq_oe == 3'b000 && dq_out == 16'h0));

    assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ce_n && !oe_n && !vpp_hi && !a9_hi && !word_sel))
        |-> (dq_oe == 3'b001 && dq_out[15:8] == 8'h00));

    assert_verify_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ce_n && !oe_n && vpp_hi)) |-> (dq_oe == 3'b111));

    assert_sig_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ce_n && !oe_n && !vpp_hi && a9_hi)) |-> (dq_out[15:8] == 8'h00));

    assert_word_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ce_n && !oe_n && !vpp_hi && !a9_hi && word_sel)) |-> (dq_oe == 3'b111));
endmodule

bind eprom_emu eprom_emu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .word_sel (word_sel),
    .vpp_hi   (vpp_hi),
    .a9_hi    (a9_hi),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
);

// File: tb/sim_eprom_emu.sv
module sim_eprom_emu;
    localparam int DEPTH = 16;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic erase = 1'b0;
    logic ce_n = 1'b1;
    logic oe_n = 1'b1;
    logic word_sel = 1'b1;
    logic vpp_hi = 1'b0;
    logic a9_hi = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [2:0] dq_oe;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    eprom_emu #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .erase(erase), .ce_n(ce_n), .oe_n(oe_n),
        .word_sel(word_sel), .vpp_hi(vpp_hi), .a9_hi(a9_hi), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct packed {
        logic        ce;
        logic        oe;
        logic        wd;
        logic        vpp;
        logic        a9;
        logic        am1;
        logic [3:0]  ad;
        logic [2:0]  eoe;
        logic [15:0] edq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd3,3'b111,16'h12C4,8'd2},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd5,3'b111,16'hA55A,8'd2},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,3'b111,16'hFFFF,8'd2},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3,3'b001,16'h00C4,8'd3},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd3,3'b001,16'h0012,8'd3},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd5,3'b001,16'h00A5,8'd3},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd3,3'b000,16'h0000,8'd4},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'd3,3'b000,16'h0000,8'd5},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'd5,3'b000,16'h0000,8'd5},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,4'd0,3'b111,16'h0020,8'd6},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,4'd1,3'b111,16'h00B8,8'd6},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd1,3'b001,16'h00B8,8'd6},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd5,3'b111,16'hA55A,8'd8},
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,4'd5,3'b000,16'h0000,8'd9}
    };

    task automatic check(input logic [2:0] eoe, input logic [15:0] edq, input string req);
        checks++;
        if (dq_oe !== eoe || dq_out !== edq) begin
            fails++;
            $display("FAIL %s: oe=%b dq=%h expected oe=%b dq=%h", req, dq_oe, dq_out, eoe, edq);
        end
    endtask

    task automatic apply(input logic c, input logic o, input logic w, input logic v,
                         input logic a9, input logic am1, input logic [AW-1:0] a);
        ce_n = c; oe_n = o; word_sel = w; vpp_hi = v; a9_hi = a9;
        addr = a; dq_in = {am1, 15'h0};
        @(negedge clk);
    endtask

    task automatic program_word(input logic [AW-1:0] a, input logic [15:0] d);
        ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b1; a9_hi = 1'b0; addr = a; dq_in = d;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        vpp_hi = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_word(input logic [AW-1:0] a, input logic [15:0] e, input string req);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a);
        check(3'b111, e, req);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(3'b000, 16'h0000, "R1 reset outputs");
        read_word(4'd7, 16'hFFFF, "R1 erased after reset");

        program_word(4'd3, 16'h12C4);
        program_word(4'd5, 16'hA55A);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].ce, VECS[i].oe, VECS[i].wd, VECS[i].vpp, VECS[i].a9,
                  VECS[i].am1, VECS[i].ad);
            check(VECS[i].eoe, VECS[i].edq, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R7: a new pattern is ANDed in, cleared bits stay cleared
        program_word(4'd3, 16'hFF0F);
        read_word(4'd3, 16'h1204, "R7 and-merge");
        program_word(4'd3, 16'hFFFF);
        read_word(4'd3, 16'h1204, "R7 no set of zero bits");

        // R9: supply high with chip enable high and no pulse leaves words intact
        ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b1; addr = 4'd5; dq_in = 16'h0000;
        repeat (4) @(negedge clk);
        check(3'b000, 16'h0000, "R9 inhibit outputs off");
        vpp_hi = 1'b0;
        read_word(4'd5, 16'hA55A, "R9 array unchanged");

        // R10: erase wins over a program commit on the same edge
        ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b1; addr = 4'd5; dq_in = 16'h0000;
        @(negedge clk);
        ce_n = 1'b1; erase = 1'b1;
        @(negedge clk);
        erase = 1'b0; vpp_hi = 1'b0;
        read_word(4'd5, 16'hFFFF, "R10 erase priority");
        read_word(4'd3, 16'hFFFF, "R10 erase all words");

        finish_run();
    end
endmodule